// File: doc/BRIEF.md
# Field Framebuffer Write Address Generator

This block supplies the memory byte address for every 32-bit word that a video capture path moves from its line FIFO into a framebuffer. Software programs two base addresses, one for the framebuffer of the first field and one for the framebuffer of the second field. Base values are always aligned to 16 bytes: the four low bits are dropped on write and read back as zero.

The block keeps a separate working address counter. The base registers act as shadow values. At each field-start strobe the counter is loaded from the base that the mode and field parity select. In interlaced mode the first field uses the first base and the second field uses the second base. In progressive mode the second base is used for every field. Each word-transferred strobe then advances the counter by one word. Because the counter is loaded only at field start, software can reprogram a base in the middle of a field without disturbing the frame being written. The new value takes effect at the next field start.

Top module: `fb_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, both base registers read as zero and `wr_addr` is zero.
- R2: A base register write (select 0 = first-field base, select 1 = second-field base) stores the data with bits [3:0] forced to 0. `rd_data` returns the base chosen by `rd_sel` with the same encoding, one cycle after the write.
- R3: In interlaced mode (`interlaced`=1), a `field_start` with `field_second`=0 loads `wr_addr` from the first-field base, and one with `field_second`=1 loads it from the second-field base. The value appears on the cycle after the strobe.
- R4: In progressive mode (`interlaced`=0), a `field_start` loads `wr_addr` from the second-field base whatever the value of `field_second`.
- R5: Each `word_done` without `field_start` raises `wr_addr` by 4 on the next cycle. With neither strobe, `wr_addr` holds its value.
- R6: A base write during a field leaves `wr_addr` unchanged. The written value is used only from the next `field_start`.
- R7: Word transfers and field starts never change the stored base values, as read back through `rd_data`.
- R8: When `field_start` and `word_done` are asserted in the same cycle, `wr_addr` takes the selected base, with no increment.
- R9: When a base write and a `field_start` fall in the same cycle, the load uses the base value held before that write.
- R10: The working address wraps modulo 2^32 when it is incremented past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Base register write enable |
| cfg_sel | input | 1 | Write target: 0 first-field base, 1 second-field base |
| cfg_wdata | input | 32 | Base address write data |
| rd_sel | input | 1 | Read select: 0 first-field base, 1 second-field base |
| rd_data | output | 32 | Selected base value, low 4 bits zero |
| interlaced | input | 1 | 1 = interlaced capture, 0 = progressive |
| field_start | input | 1 | One-cycle strobe at the start of a field |
| field_second | input | 1 | Field parity with the strobe: 0 first, 1 second |
| word_done | input | 1 | One-cycle strobe per 32-bit word transferred |
| wr_addr | output | 32 | Current framebuffer write byte address |

## Verification
The assertions assume that the strobes are single-cycle pulses sampled on the clock edge, and that `field_second` and `interlaced` are valid whenever `field_start` is high. They place no other limit on when the strobes arrive. The stimulus changes every input only on the falling edge and holds it for exactly one rising edge. This keeps coincident events at one exact cycle: field start with a transfer, and a base write with a field start. The stimulus also drives a counter across the top of the address space to exercise wrap-around.

// File: rtl/fb_addr_pkg.sv
package fb_addr_pkg;

    parameter int ADDR_W     = 32;
    parameter int ALIGN_BITS = 4;
    parameter int WORD_BYTES = 4;
    parameter int NUM_FIELDS = 2;

    localparam int SEL_W = $clog2(NUM_FIELDS);

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [SEL_W-1:0] {
        FIELD_FIRST  = 1'b0,
        FIELD_SECOND = 1'b1
    } field_e;

    typedef struct packed {
        logic   load;
        logic   step;
        field_e src;
    } ctr_cmd_t;

    function automatic addr_t align_base(input addr_t raw);
        addr_t mask;
        mask = '1;
        mask[ALIGN_BITS-1:0] = '0;
        return raw & mask;
    endfunction

    function automatic field_e pick_source(input logic inter, input logic second);
        if (!inter)
            return FIELD_SECOND;
        return second ? FIELD_SECOND : FIELD_FIRST;
    endfunction

endpackage

// File: rtl/fb_base_regs.sv
module fb_base_regs
    import fb_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  field_e wsel,
    input  addr_t wdata,
    input  field_e rsel,
    output addr_t rdata,
    output addr_t base_q [NUM_FIELDS]
);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_base
        always_ff @(posedge clk) begin
            if (rst)
                base_q[g] <= '0;
            else if (we && (int'(wsel) == g))
                base_q[g] <= align_base(wdata);
        end

        a_r7_base_hold: assert property (@(posedge clk) disable iff (rst)
            !(we && (int'(wsel) == g)) |=> $stable(base_q[g]));

        a_r2_low_zero: assert property (@(posedge clk) disable iff (rst)
            we && (int'(wsel) == g) |=> base_q[g][ALIGN_BITS-1:0] == '0);
    end

    assign rdata = base_q[rsel];

endmodule

// File: rtl/fb_addr_ctr.sv
module fb_addr_ctr
    import fb_addr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctr_cmd_t cmd,
    input  addr_t    base_in [NUM_FIELDS],
    output addr_t    addr_q
);

    localparam addr_t STEP = addr_t'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (cmd.load)
            addr_q <= base_in[cmd.src];
        else if (cmd.step)
            addr_q <= addr_q + STEP;
    end

    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && cmd.step) |=> addr_q == $past(addr_q) + STEP);

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && !cmd.step) |=> $stable(addr_q));

    a_r8_load_aligned: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> addr_q[ALIGN_BITS-1:0] == '0);

endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
    import fb_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    input  logic        interlaced,
    input  logic        field_start,
    input  logic        field_second,
    input  logic        word_done,
    output logic [31:0] wr_addr
);

    addr_t    bases [NUM_FIELDS];
    ctr_cmd_t cmd;

    fb_base_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wsel   (field_e'(cfg_sel)),
        .wdata  (cfg_wdata),
        .rsel   (field_e'(rd_sel)),
        .rdata  (rd_data),
        .base_q (bases)
    );

    always_comb begin
        cmd.load = field_start;
        cmd.step = word_done;
        cmd.src  = pick_source(interlaced, field_second);
    end

    fb_addr_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .base_in (bases),
        .addr_q  (wr_addr)
    );

    a_r4_progressive: assert property (@(posedge clk) disable iff (rst)
        (field_start && !interlaced) |=> wr_addr == $past(bases[1]));

    a_r3_interlaced: assert property (@(posedge clk) disable iff (rst)
        (field_start && interlaced) |=>
            wr_addr == (($past(field_second)) ? $past(bases[1]) : $past(bases[0])));

endmodule

// File: tb/fb_addr_gen_test.sv
module fb_addr_gen_test;

    logic        clk = 0;
    logic        rst;
    logic        cfg_we, cfg_sel, rd_sel;
    logic [31:0] cfg_wdata, rd_data, wr_addr;
    logic        interlaced, field_start, field_second, word_done;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [31:0] addr;
        string       tag;
    } exp_t;

    exp_t        sb [$];
    logic [31:0] m_base [2];
    logic [31:0] m_addr;

    always #10 clk = ~clk;

    fb_addr_gen uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .interlaced(interlaced), .field_start(field_start),
        .field_second(field_second), .word_done(word_done), .wr_addr(wr_addr)
    );

    // monitor: compares the design address against the scoreboard
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (wr_addr !== e.addr) begin
                bad++;
                $display("FAIL %s wr_addr actual=%h expected=%h", e.tag, wr_addr, e.addr);
            end
        end
    end

    task automatic cyc(input logic we, input logic wsel, input logic [31:0] wd,
                       input logic fs, input logic sec, input logic wdn, input string tag);
        logic [31:0] nxt;
        @(negedge clk);
        cfg_we = we; cfg_sel = wsel; cfg_wdata = wd;
        field_start = fs; field_second = sec; word_done = wdn;
        if (fs)
            nxt = interlaced ? m_base[sec] : m_base[1];
        else if (wdn)
            nxt = m_addr + 32'd4;
        else
            nxt = m_addr;
        m_addr = nxt;
        if (we) m_base[wsel] = wd & 32'hFFFF_FFF0;
        @(posedge clk);
        #1;
        sb.push_back('{nxt, tag});
    endtask

    task automatic chk_read(input logic sel, input string tag);
        @(negedge clk);
        cfg_we = 0; field_start = 0; word_done = 0;
        rd_sel = sel;
        #1;
        total++;
        if (rd_data !== m_base[sel]) begin
            bad++;
            $display("FAIL %s rd_data[%0d] actual=%h expected=%h", tag, sel, rd_data, m_base[sel]);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; rd_sel = 0;
        interlaced = 1; field_start = 0; field_second = 0; word_done = 0;
        m_base[0] = 0; m_base[1] = 0; m_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk_read(0, "R1");
        chk_read(1, "R1");
        cyc(0, 0, 0, 0, 0, 0, "R1");

        // R2 aligned writes
        cyc(1, 0, 32'h1000_0007, 0, 0, 0, "R2");
        cyc(1, 1, 32'h2000_00FF, 0, 0, 0, "R2");
        chk_read(0, "R2");
        chk_read(1, "R2");

        // R3 interlaced first field
        interlaced = 1;
        cyc(0, 0, 0, 1, 0, 0, "R3");
        // R5 increments and hold
        cyc(0, 0, 0, 0, 0, 1, "R5");
        cyc(0, 0, 0, 0, 0, 1, "R5");
        cyc(0, 0, 0, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, 1, "R5");
        // R6 mid-field write does not disturb counter
        cyc(1, 0, 32'h3000_0040, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 1, "R6");
        chk_read(0, "R6");
        // R3 second field uses second base
        cyc(0, 0, 0, 1, 1, 0, "R3");
        cyc(0, 0, 0, 0, 0, 1, "R3");
        // R6 new first-field base takes effect at next field start
        cyc(0, 0, 0, 1, 0, 0, "R6");

        // R4 progressive uses second base for both parities
        interlaced = 0;
        cyc(0, 0, 0, 1, 0, 0, "R4");
        cyc(0, 0, 0, 0, 0, 1, "R4");
        cyc(0, 0, 0, 1, 1, 0, "R4");

        // R8 field start with transfer in the same cycle
        cyc(0, 0, 0, 0, 0, 1, "R8");
        cyc(0, 0, 0, 1, 0, 1, "R8");

        // R9 write coincident with field start uses old value
        cyc(1, 1, 32'h4444_4444, 1, 0, 0, "R9");
        cyc(0, 0, 0, 1, 0, 0, "R9");

        // R10 wrap-around
        cyc(1, 1, 32'hFFFF_FFF3, 0, 0, 0, "R10");
        cyc(0, 0, 0, 1, 1, 0, "R10");
        for (int i = 0; i < 6; i++)
            cyc(0, 0, 0, 0, 0, 1, "R10");

        // R7 bases untouched by transfers and loads
        chk_read(0, "R7");
        chk_read(1, "R7");

        cyc(0, 0, 0, 0, 0, 0, "R5");
        @(negedge clk);
        @(negedge clk);
        finish_up();
    end

endmodule